// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 bit patterns and encodes the result as integer condition flags. A downstream branch or select unit can then test for above, below, equal or unordered without any floating-point logic of its own. The `is_double` input picks the width of both operands. In single mode only the low 32 bits of each operand are read, and the upper bits may hold anything.

The result describes the compare operand (`src_cmp`) relative to the reference operand (`src_ref`). When either operand is a NaN the result is unordered, and carry, zero and parity are all set. A strictly lower compare operand sets carry alone. Equal operands set zero alone. A strictly higher compare operand leaves all three clear. Overflow and sign are cleared by every compare.

A one-cycle `cmp_go` strobe captures a compare. The flag register takes the result at the next rising clock edge and holds it until the next strobe.

Top module: `fpcmp_flags`

## Requirements
- R1: During and after reset, and until the first strobe, all five flag outputs are 0.
- R2: If `src_cmp` < `src_ref`, then {CF,ZF,PF} = 3'b100.
- R3: If `src_cmp` equals `src_ref` and neither is a NaN, then {CF,ZF,PF} = 3'b010.
- R4: If `src_cmp` > `src_ref`, then {CF,ZF,PF} = 3'b000.
- R5: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, then {CF,ZF,PF} = 3'b111.
- R6: Positive zero and negative zero compare equal.
- R7: Infinities are ordinary ordered values. +inf is above every finite value, -inf is below every finite value, and two infinities of the same sign are equal.
- R8: When both operands are negative, the larger magnitude is the lower value.
- R9: In single mode (`is_double`=0) bits 63:32 of both operands have no effect on the result. The sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0. In double mode the sign is bit 63, the exponent is bits 62:52 and the fraction is bits 51:0.
- R10: `flag_of` and `flag_sf` are 0 after every compare.
- R11: The flags change only at the clock edge that samples `cmp_go`=1. They hold their value while `cmp_go` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_go | input | 1 | Strobe that captures a compare |
| is_double | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| src_ref | input | 64 | Reference operand (s1) |
| src_cmp | input | 64 | Compared operand (s2) |
| flag_cf | output | 1 | Carry: below or unordered |
| flag_zf | output | 1 | Zero: equal or unordered |
| flag_pf | output | 1 | Parity: unordered |
| flag_of | output | 1 | Overflow, always cleared |
| flag_sf | output | 1 | Sign, always cleared |

## Verification
Every result is due one clock edge after the strobe. The operands and `cmp_go` are sampled at a rising edge, and the registered flags show the result right after that edge. The bench drives the operands and the strobe on a falling edge and lowers the strobe on the next falling edge. At that second falling edge it reads the flags, which fall exactly one register stage after the strobe. For the hold case the bench changes the operands with the strobe low, waits several edges and reads the flags again.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int DBL_W    = 64;
    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;
    localparam int SGL_W    = 32;
    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int MAG_W    = DBL_W - 1;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } operand_t;

    typedef struct packed {
        logic cf;
        logic zf;
        logic pf;
    } cond_t;
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  logic [DBL_W-1:0] raw,
    input  logic             is_double,
    output operand_t         opnd
);
    logic                sgl_nan, dbl_nan;
    logic [MAG_W-1:0]    sgl_mag, dbl_mag;

    assign dbl_nan = (&raw[DBL_W-2 -: DBL_EXP]) && (|raw[DBL_FRAC-1:0]);
    assign sgl_nan = (&raw[SGL_W-2 -: SGL_EXP]) && (|raw[SGL_FRAC-1:0]);
    assign dbl_mag = raw[DBL_W-2:0];
    assign sgl_mag = {{(DBL_W-SGL_W){1'b0}}, raw[SGL_W-2:0]};

    always_comb begin
        if (is_double) begin
            opnd.sign = raw[DBL_W-1];
            opnd.nan  = dbl_nan;
            opnd.mag  = dbl_mag;
        end else begin
            opnd.sign = raw[SGL_W-1];
            opnd.nan  = sgl_nan;
            opnd.mag  = sgl_mag;
        end
        opnd.zero = (opnd.mag == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  operand_t ref_op,
    input  operand_t cmp_op,
    output order_e   order
);
    logic mag_lt, mag_eq;

    assign mag_lt = (cmp_op.mag < ref_op.mag);
    assign mag_eq = (cmp_op.mag == ref_op.mag);

    always_comb begin
        if (ref_op.nan || cmp_op.nan) begin
            order = ORD_UN;
        end else if (ref_op.zero && cmp_op.zero) begin
            order = ORD_EQ;
        end else if (ref_op.sign != cmp_op.sign) begin
            order = cmp_op.sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            order = ORD_EQ;
        end else if (ref_op.sign) begin
            order = mag_lt ? ORD_GT : ORD_LT;
        end else begin
            order = mag_lt ? ORD_LT : ORD_GT;
        end
    end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_go,
    input  logic             is_double,
    input  logic [DBL_W-1:0] src_ref,
    input  logic [DBL_W-1:0] src_cmp,
    output logic             flag_cf,
    output logic             flag_zf,
    output logic             flag_pf,
    output logic             flag_of,
    output logic             flag_sf
);
    operand_t ref_op, cmp_op;
    order_e   order;
    cond_t    cond_nxt, cond_q;

    fpcmp_unpack u_unpack_ref (.raw(src_ref), .is_double(is_double), .opnd(ref_op));
    fpcmp_unpack u_unpack_cmp (.raw(src_cmp), .is_double(is_double), .opnd(cmp_op));
    fpcmp_order  u_order      (.ref_op(ref_op), .cmp_op(cmp_op), .order(order));

    always_comb begin
        unique case (order)
            ORD_LT:  cond_nxt = '{cf: 1'b1, zf: 1'b0, pf: 1'b0};
            ORD_EQ:  cond_nxt = '{cf: 1'b0, zf: 1'b1, pf: 1'b0};
            ORD_GT:  cond_nxt = '{cf: 1'b0, zf: 1'b0, pf: 1'b0};
            default: cond_nxt = '{cf: 1'b1, zf: 1'b1, pf: 1'b1};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cond_q <= '0;
        else if (cmp_go) cond_q <= cond_nxt;
    end

    assign flag_cf = cond_q.cf;
    assign flag_zf = cond_q.zf;
    assign flag_pf = cond_q.pf;
    assign flag_of = 1'b0;
    assign flag_sf = 1'b0;
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_go,
    input logic        is_double,
    input logic [63:0] src_ref,
    input logic [63:0] src_cmp,
    input logic        flag_cf,
    input logic        flag_zf,
    input logic        flag_pf,
    input logic        flag_of,
    input logic        flag_sf
);
    p_of_sf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_of && !flag_sf);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> $stable({flag_cf, flag_zf, flag_pf}));

    p_parity_only_unord_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pf |-> (flag_cf && flag_zf));

    p_cf_zf_means_unord_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cf && flag_zf) |-> flag_pf);

    p_dbl_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && is_double && (&src_ref[62:52]) && (|src_ref[51:0])) |=> flag_pf);

    p_same_bits_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && is_double && (src_ref == src_cmp) && !(&src_ref[62:52]))
        |=> (flag_zf && !flag_cf && !flag_pf));
endmodule

bind fpcmp_flags fpcmp_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .is_double(is_double),
    .src_ref(src_ref), .src_cmp(src_cmp),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_pf(flag_pf),
    .flag_of(flag_of), .flag_sf(flag_sf)
);

// File: tb/fpcmp_flags_tb.sv
module fpcmp_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_go = 1'b0;
    logic        is_double = 1'b0;
    logic [63:0] src_ref = '0;
    logic [63:0] src_cmp = '0;
    logic        flag_cf, flag_zf, flag_pf, flag_of, flag_sf;
    int          checks = 0;
    int          failures = 0;

    localparam logic [2:0] LT = 3'b100, EQ = 3'b010, GT = 3'b000, UN = 3'b111;

    always #2 clk = ~clk;

    fpcmp_flags u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .is_double(is_double),
        .src_ref(src_ref), .src_cmp(src_cmp),
        .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_pf(flag_pf),
        .flag_of(flag_of), .flag_sf(flag_sf)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic run_cmp(input string req, input logic dbl,
                           input logic [63:0] r, input logic [63:0] c,
                           input logic [2:0] exp);
        @(negedge clk);
        is_double = dbl; src_ref = r; src_cmp = c; cmp_go = 1'b1;
        @(negedge clk);
        cmp_go = 1'b0;
        check(req, {flag_cf, flag_zf, flag_pf, flag_of, flag_sf}, {exp, 2'b00});
    endtask

    task automatic t_reset();
        check("R1", {flag_cf, flag_zf, flag_pf, flag_of, flag_sf}, 5'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", {flag_cf, flag_zf, flag_pf, flag_of, flag_sf}, 5'b0);
    endtask

    task automatic t_basic_single();
        run_cmp("R2", 1'b0, 64'h4000_0000, 64'h3F80_0000, LT);
        run_cmp("R3", 1'b0, 64'h3F80_0000, 64'h3F80_0000, EQ);
        run_cmp("R4", 1'b0, 64'h3F80_0000, 64'h4000_0000, GT);
        run_cmp("R4", 1'b0, 64'hBF80_0000, 64'h3F80_0000, GT);
    endtask

    task automatic t_basic_double();
        run_cmp("R2", 1'b1, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, LT);
        run_cmp("R4", 1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, GT);
        run_cmp("R3", 1'b1, 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000, EQ);
    endtask

    task automatic t_nan();
        run_cmp("R5", 1'b0, 64'h7FC0_0000, 64'h3F80_0000, UN);
        run_cmp("R5", 1'b0, 64'h3F80_0000, 64'hFF80_0001, UN);
        run_cmp("R5", 1'b1, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, UN);
        run_cmp("R5", 1'b1, 64'h0, 64'h7FF0_0000_0000_0001, UN);
    endtask

    task automatic t_zero();
        run_cmp("R6", 1'b0, 64'h0000_0000, 64'h8000_0000, EQ);
        run_cmp("R6", 1'b1, 64'h8000_0000_0000_0000, 64'h0, EQ);
    endtask

    task automatic t_inf();
        run_cmp("R7", 1'b0, 64'h7F80_0000, 64'h7F7F_FFFF, LT);
        run_cmp("R7", 1'b0, 64'hFF80_0000, 64'hFF7F_FFFF, GT);
        run_cmp("R7", 1'b1, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, EQ);
        run_cmp("R7", 1'b1, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, LT);
    endtask

    task automatic t_negative();
        run_cmp("R8", 1'b0, 64'hBF80_0000, 64'hC000_0000, LT);
        run_cmp("R8", 1'b1, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, GT);
    endtask

    task automatic t_single_upper();
        run_cmp("R9", 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, EQ);
        run_cmp("R9", 1'b0, 64'hFFF8_0000_4000_0000, 64'h0000_0000_3F80_0000, LT);
        run_cmp("R9", 1'b0, 64'h0000_0000_3F80_0000, 64'h7FF8_0000_4000_0000, GT);
    endtask

    task automatic t_hold();
        run_cmp("R11", 1'b0, 64'h3F80_0000, 64'h3F80_0000, EQ);
        @(negedge clk);
        src_ref = 64'h4000_0000; src_cmp = 64'h7FC0_0000;
        repeat (4) @(negedge clk);
        check("R11", {flag_cf, flag_zf, flag_pf, flag_of, flag_sf}, {EQ, 2'b00});
        run_cmp("R10", 1'b1, 64'h0, 64'hBFF0_0000_0000_0000, LT);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_basic_single();
        t_basic_double();
        t_nan();
        t_zero();
        t_inf();
        t_negative();
        t_single_upper();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule